// File: doc/BRIEF.md
# SPI Burst-Length Transfer Sequencer

This block sits between a 32-bit transmit queue and an SPI byte shifter. Software writes a control word and pushes transmit words. When an exchange starts, the sequencer pops words and sends each one as a short run of bytes, most significant active byte first. It packs the bytes that come back into a 32-bit word and queues that word for software to read. A burst-length field in the control word sets how many bits make up one burst. The sequencer uses that count to decide how many bytes each word carries and when a burst ends. It also decides whether the exchange stops at the end of a burst or runs on until the transmit queue is empty.

The SPI shifter is reached through a request/done byte handshake; serial clock generation belongs to the shifter. Four active-low chip selects follow the channel chosen in the control word. Two sticky flags report a completed transfer and a dropped receive word. Software clears them by write-one-to-clear.

Control word layout:

| Bits | Field |
|------|-------|
| 0 | enable |
| 1 | go: exchange request, also a running indication |
| 2 | auto-go |
| 3 | spare |
| 7:4 | per-channel master mask |
| 9:8 | channel select |
| 13:10 | per-channel chain mask |
| 25:14 | burst field |
| 31:26 | reserved |

Top module: `spi_burst_seq`

## Requirements
- R1: The burst length in bits is the burst field plus one, rounded up to the next multiple of 8 when it is not already one. For example, field 9 gives 16 bits.
- R2: On each word popped, the sequencer first takes the remaining burst bits, reloading them from R1 when the remainder is zero. The word then carries that remainder mod 32 bits, or 32 bits when the result is 0. These go out as whole bytes, starting at the most significant active byte and moving downward.
- R3: Each received byte is shifted into the receive word from the right (word = word<<8 | byte), starting from zero. The word is pushed once all bytes of its transmit word are exchanged.
- R4: If the receive queue is full when a word completes, the word is dropped and the overflow flag (rx_ovf_o) is set. The flag stays set until stat_clr_i[0] is pulsed while the block is enabled.
- R5: The remaining burst count drops by 8 per byte. When it reaches zero outside chain mode, xfer_done_o is set and the sequencer stops, even if words remain in the transmit queue. In that case go stays set. xfer_done_o is cleared by stat_clr_i[1].
- R6: Chain mode is active when the selected channel is master, auto-go is clear and the selected channel's chain bit is set. In chain mode the exchange runs on across bursts, and go is set again at each burst start.
- R7: When the sequencer finds the transmit queue empty, it sets xfer_done_o, clears go and stops.
- R8: Draining starts in three cases, and each needs the block enabled and the selected channel master. (a) A transmit write is accepted while auto-go is set. (b) A control write sets auto-go from clear while the transmit queue holds data. (c) A control write sets go from clear with auto-go clear. Without one of these, queued words are not sent.
- R9: A control write with enable set and the selected channel master drives the chip select of the selected channel (0 to 3) low and the others high. Other control writes leave the chip selects unchanged.
- R10: While disabled, transmit writes, receive pops and flag clears are ignored. A control write with enable clear aborts any transfer, flushes both queues, clears both flags, zeroes the remaining burst count and drives all chip selects high.
- R11: The outgoing byte on spi_tx_byte_o is held stable while spi_req_o is high until spi_done_i is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word value |
| ctrl_o | output | 32 | Current control word (go reflects sequencer updates) |
| tx_we_i | input | 1 | Transmit word write strobe |
| tx_wdata_i | input | 32 | Transmit word |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_re_i | input | 1 | Pop the receive queue head |
| rx_rdata_o | output | 32 | Receive queue head |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_full_o | output | 1 | Receive queue full |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 transfer done |
| rx_ovf_o | output | 1 | Receive overflow flag |
| xfer_done_o | output | 1 | Transfer complete flag |
| busy_o | output | 1 | Sequencer active |
| spi_req_o | output | 1 | Byte exchange request to the shifter |
| spi_tx_byte_o | output | 8 | Byte to send |
| spi_done_i | input | 1 | Shifter finished the byte |
| spi_rx_byte_i | input | 8 | Byte received, valid with done |
| cs_no | output | 4 | Active-low chip selects |

## Verification
The main function is tried with four burst lengths and start modes:
- A full 32-bit burst started by auto-go shows byte order and receive packing on a complete word.
- A 10-bit field shows the rounding and the partial-word path, where only the low bytes are sent.
- A 40-bit burst started by go puts a one-byte word ahead of a full word. It tells the remainder rule apart from a fixed word size, and shows a stop that leaves a word queued.
- A chained 16-bit case shows that the exchange runs on across bursts, where a plain burst would stop.

The other patterns are narrower:
- A filled receive queue shows the drop and overflow behaviour.
- A queued word sent only when auto-go is set shows the deferred start.
- A long byte cut short by disabling, followed by a single-byte burst, shows that the abort also resets the remaining count.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int unsigned NUM_CS  = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_CS);
  localparam int unsigned BURST_W = 12;
  localparam int unsigned BLEN_W  = BURST_W + 1;
  localparam int unsigned RSVD_W  = 32 - 4 - BURST_W - 2 * NUM_CS - SEL_W;

  typedef struct packed {
    logic [RSVD_W-1:0]  rsvd;
    logic [BURST_W-1:0] burst;
    logic [NUM_CS-1:0]  chain;
    logic [SEL_W-1:0]   sel;
    logic [NUM_CS-1:0]  master;
    logic               spare;
    logic               auto_go;
    logic               go;
    logic               en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_BYTE,
    SQ_PUSH
  } seq_state_e;

  function automatic logic is_master(ctrl_t c);
    return c.master[c.sel];
  endfunction

  function automatic logic is_chain(ctrl_t c);
    return c.master[c.sel] && !c.auto_go && c.chain[c.sel];
  endfunction

  // field + 1, rounded up to whole bytes
  function automatic logic [BLEN_W-1:0] burst_bits(ctrl_t c);
    logic [BLEN_W-1:0] b;
    b = {1'b0, c.burst} + BLEN_W'(1);
    if (b[2:0] != 3'd0) b = {b[BLEN_W-1:3] + 1'b1, 3'b000};
    return b;
  endfunction
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  logic do_push, do_pop;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ctrl_t       ctrl_i,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        tx_empty_i,
  input  logic [31:0] tx_data_i,
  output logic        tx_pop_o,
  input  logic        rx_full_i,
  output logic        rx_push_o,
  output logic [31:0] rx_data_o,
  output logic        ovf_set_o,
  output logic        tc_set_o,
  output logic        go_set_o,
  output logic        go_clr_o,
  output logic        busy_o,
  output logic        spi_req_o,
  output logic [7:0]  spi_tx_byte_o,
  input  logic        spi_done_i,
  input  logic [7:0]  spi_rx_byte_i
);
  seq_state_e        st_q, st_d;
  logic [BLEN_W-1:0] rem_q, rem_d;
  logic [31:0]       sh_q, sh_d;
  logic [31:0]       acc_q, acc_d;
  logic [2:0]        nb_q, nb_d;

  logic              chain;
  logic [BLEN_W-1:0] rem_eff;
  logic [4:0]        word_bits;
  logic [2:0]        word_bytes;
  logic [5:0]        align_sh;

  assign chain      = is_chain(ctrl_i);
  assign rem_eff    = (rem_q == '0) ? burst_bits(ctrl_i) : rem_q;
  assign word_bits  = rem_eff[4:0];
  assign word_bytes = (word_bits == 5'd0) ? 3'd4 : {1'b0, word_bits[4:3]};
  assign align_sh   = {3'd4 - word_bytes, 3'b000};

  assign busy_o        = (st_q != SQ_IDLE);
  assign spi_req_o     = (st_q == SQ_BYTE);
  assign spi_tx_byte_o = sh_q[31:24];
  assign rx_data_o     = acc_q;

  always_comb begin
    st_d      = st_q;
    rem_d     = rem_q;
    sh_d      = sh_q;
    acc_d     = acc_q;
    nb_d      = nb_q;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    ovf_set_o = 1'b0;
    tc_set_o  = 1'b0;
    go_set_o  = 1'b0;
    go_clr_o  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_i) st_d = SQ_CHECK;
      SQ_CHECK: begin
        if (tx_empty_i) begin
          tc_set_o = 1'b1;
          go_clr_o = 1'b1;
          st_d     = SQ_IDLE;
        end else begin
          if (rem_q == '0 && chain) go_set_o = 1'b1;
          tx_pop_o = 1'b1;
          rem_d    = rem_eff;
          sh_d     = tx_data_i << align_sh;
          acc_d    = '0;
          nb_d     = word_bytes;
          st_d     = SQ_BYTE;
        end
      end
      SQ_BYTE: begin
        if (spi_done_i) begin
          acc_d = {acc_q[23:0], spi_rx_byte_i};
          sh_d  = {sh_q[23:0], 8'h00};
          rem_d = rem_q - BLEN_W'(8);
          nb_d  = nb_q - 3'd1;
          if (nb_q == 3'd1) st_d = SQ_PUSH;
        end
      end
      SQ_PUSH: begin
        if (rx_full_i) ovf_set_o = 1'b1;
        else           rx_push_o = 1'b1;
        if (rem_q == '0 && !chain) begin
          tc_set_o = 1'b1;
          go_clr_o = tx_empty_i;
          st_d     = SQ_IDLE;
        end else begin
          st_d = SQ_CHECK;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      rem_q <= '0;
      sh_q  <= '0;
      acc_q <= '0;
      nb_q  <= '0;
    end else if (abort_i) begin
      st_q  <= SQ_IDLE;
      rem_q <= '0;
      nb_q  <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      sh_q  <= sh_d;
      acc_q <= acc_d;
      nb_q  <= nb_d;
    end
  end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_o,
  input  logic              tx_we_i,
  input  logic [31:0]       tx_wdata_i,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  input  logic              rx_re_i,
  output logic [31:0]       rx_rdata_o,
  output logic              rx_valid_o,
  output logic              rx_full_o,
  input  logic [1:0]        stat_clr_i,
  output logic              rx_ovf_o,
  output logic              xfer_done_o,
  output logic              busy_o,
  output logic              spi_req_o,
  output logic [7:0]        spi_tx_byte_o,
  input  logic              spi_done_i,
  input  logic [7:0]        spi_rx_byte_i,
  output logic [NUM_CS-1:0] cs_no
);
  ctrl_t ctrl_q, wctrl;
  logic  en, soft_rst;
  logic  tx_push, tx_pop, tx_empty, tx_full;
  logic  rx_push, rx_pop, rx_empty, rx_full;
  logic [31:0] tx_head, rx_word;
  logic  ovf_set, tc_set, go_set, go_clr;
  logic  start_tx, start_ctrl, start;
  logic  ovf_q, tc_q;
  logic [NUM_CS-1:0] cs_sel_n, cs_q;

  assign wctrl    = ctrl_t'(ctrl_wdata_i);
  assign en       = ctrl_q.en;
  assign soft_rst = ctrl_we_i && !wctrl.en;

  assign tx_push = tx_we_i && en && !tx_full && !soft_rst;
  assign rx_pop  = rx_re_i && en && !rx_empty;

  assign start_tx   = tx_push && !ctrl_we_i && is_master(ctrl_q) && ctrl_q.auto_go;
  assign start_ctrl = ctrl_we_i && wctrl.en && is_master(wctrl) &&
                      ((wctrl.auto_go && !ctrl_q.auto_go && !tx_empty) ||
                       (wctrl.go && !ctrl_q.go && !wctrl.auto_go));
  assign start      = start_tx || start_ctrl;

  spi_seq_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .flush_i (soft_rst),
    .push_i  (tx_push),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_pop),
    .head_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  spi_seq_fifo #(.WIDTH(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i (soft_rst),
    .push_i  (rx_push),
    .wdata_i (rx_word),
    .pop_i   (rx_pop),
    .head_o  (rx_rdata_o),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spi_seq_engine u_eng (
    .clk_i, .rst_ni,
    .ctrl_i        (ctrl_q),
    .start_i       (start),
    .abort_i       (soft_rst),
    .tx_empty_i    (tx_empty),
    .tx_data_i     (tx_head),
    .tx_pop_o      (tx_pop),
    .rx_full_i     (rx_full),
    .rx_push_o     (rx_push),
    .rx_data_o     (rx_word),
    .ovf_set_o     (ovf_set),
    .tc_set_o      (tc_set),
    .go_set_o      (go_set),
    .go_clr_o      (go_clr),
    .busy_o        (busy_o),
    .spi_req_o     (spi_req_o),
    .spi_tx_byte_o (spi_tx_byte_o),
    .spi_done_i    (spi_done_i),
    .spi_rx_byte_i (spi_rx_byte_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_q    <= '0;
    else if (ctrl_we_i)   ctrl_q    <= wctrl;
    else if (go_set)      ctrl_q.go <= 1'b1;
    else if (go_clr)      ctrl_q.go <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      tc_q  <= 1'b0;
    end else if (soft_rst) begin
      ovf_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      if (ovf_set)                  ovf_q <= 1'b1;
      else if (stat_clr_i[0] && en) ovf_q <= 1'b0;
      if (tc_set)                   tc_q  <= 1'b1;
      else if (stat_clr_i[1] && en) tc_q  <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_sel_n[c] = (wctrl.sel != SEL_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cs_q <= '1;
    else if (soft_rst)                           cs_q <= '1;
    else if (ctrl_we_i && is_master(wctrl))      cs_q <= cs_sel_n;
  end

  assign ctrl_o      = ctrl_q;
  assign tx_empty_o  = tx_empty;
  assign tx_full_o   = tx_full;
  assign rx_valid_o  = !rx_empty;
  assign rx_full_o   = rx_full;
  assign rx_ovf_o    = ovf_q;
  assign xfer_done_o = tc_q;
  assign cs_no       = cs_q;
endmodule

// File: rtl/spi_burst_seq_chk.sv
module spi_burst_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [31:0] ctrl_wdata_i,
  input logic [31:0] ctrl_o,
  input logic [1:0]  stat_clr_i,
  input logic        rx_ovf_o,
  input logic        xfer_done_o,
  input logic        tx_empty_o,
  input logic        busy_o,
  input logic        spi_req_o,
  input logic [7:0]  spi_tx_byte_o,
  input logic        spi_done_i,
  input logic [3:0]  cs_no
);
  logic off_wr;
  assign off_wr = ctrl_we_i && !ctrl_wdata_i[0];

  a_r11_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && !spi_done_i && !off_wr) |=> (spi_req_o && $stable(spi_tx_byte_o)));

  a_r9_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  a_r10_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |-> (!spi_req_o && !busy_o));

  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && !stat_clr_i[0] && !off_wr) |=> rx_ovf_o);

  a_r7_drain_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && tx_empty_o && !$past(ctrl_we_i)) |-> (!ctrl_o[1] && xfer_done_o));
endmodule

bind spi_burst_seq spi_burst_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_wdata_i  (ctrl_wdata_i),
  .ctrl_o        (ctrl_o),
  .stat_clr_i    (stat_clr_i),
  .rx_ovf_o      (rx_ovf_o),
  .xfer_done_o   (xfer_done_o),
  .tx_empty_o    (tx_empty_o),
  .busy_o        (busy_o),
  .spi_req_o     (spi_req_o),
  .spi_tx_byte_o (spi_tx_byte_o),
  .spi_done_i    (spi_done_i),
  .cs_no         (cs_no)
);

// File: tb/tb_spi_burst_seq.sv
module tb_spi_burst_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rd;
  logic        tx_we = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_empty, tx_full;
  logic        rx_re = 1'b0;
  logic [31:0] rx_rdata;
  logic        rx_valid, rx_full;
  logic [1:0]  stat_clr = '0;
  logic        rx_ovf, xfer_done, busy;
  logic        spi_req;
  logic [7:0]  spi_tx;
  logic        spi_done;
  logic [7:0]  spi_rx;
  logic [3:0]  cs_n;

  int checks = 0;
  int fails  = 0;
  int slave_lat = 2;
  logic [7:0] log_b [64];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_rd),
    .tx_we_i(tx_we), .tx_wdata_i(tx_wdata), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_re_i(rx_re), .rx_rdata_o(rx_rdata), .rx_valid_o(rx_valid), .rx_full_o(rx_full),
    .stat_clr_i(stat_clr), .rx_ovf_o(rx_ovf), .xfer_done_o(xfer_done), .busy_o(busy),
    .spi_req_o(spi_req), .spi_tx_byte_o(spi_tx), .spi_done_i(spi_done),
    .spi_rx_byte_i(spi_rx), .cs_no(cs_n)
  );

  // byte shifter model: answers each byte with byte ^ A5 after slave_lat cycles
  initial begin
    int cnt;
    cnt = 0;
    spi_done = 1'b0;
    spi_rx = '0;
    forever begin
      @(negedge clk);
      if (spi_done) spi_done = 1'b0;
      else if (spi_req) begin
        cnt++;
        if (cnt >= slave_lat) begin
          spi_done = 1'b1;
          spi_rx = spi_tx ^ 8'hA5;
          if (log_n < 64) log_b[log_n] = spi_tx;
          log_n++;
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  function automatic logic [31:0] mk(bit e, bit g, bit ag, logic [3:0] m,
                                     logic [1:0] s, logic [3:0] ch, logic [11:0] b);
    return 32'(e) | (32'(g) << 1) | (32'(ag) << 2) | (32'(m) << 4) |
           (32'(s) << 8) | (32'(ch) << 10) | (32'(b) << 14);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic tx_wr(logic [31:0] v);
    @(negedge clk); tx_we = 1'b1; tx_wdata = v;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic clr(logic [1:0] v);
    @(negedge clk); stat_clr = v;
    @(negedge clk); stat_clr = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); v = rx_rdata; rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic fresh();
    ctrl_wr(32'h0);
    log_n = 0;
    slave_lat = 2;
  endtask

  task automatic t_reset();
    chk("R10 reset cs", 32'(cs_n), 32'hF);
    chk("R10 reset empty", {tx_empty, rx_valid, rx_ovf, xfer_done, spi_req}, 32'b10000);
    tx_wr(32'h1234);
    chk("R10 tx write ignored when off", 32'(tx_empty), 32'd1);
  endtask

  task automatic t_full_word();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd31));
    chk("R9 cs ch0", 32'(cs_n), 32'hE);
    tx_wr(32'h11223344);
    wait_idle();
    chk("R2 byte count 32b", 32'(log_n), 32'd4);
    chk("R2 msb first", {log_b[0], log_b[1], log_b[2], log_b[3]}, 32'h11223344);
    chk("R7 done flag", 32'(xfer_done), 32'd1);
    chk("R7 go cleared", 32'(ctrl_rd[1]), 32'd0);
    rd(w);
    chk("R3 rx packed", w, 32'hB48796E1);
    clr(2'b10);
    chk("R5 done cleared", 32'(xfer_done), 32'd0);
  endtask

  task automatic t_round();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd9));
    tx_wr(32'hAABBCCDD);
    wait_idle();
    chk("R1 rounded to 16 bits", 32'(log_n), 32'd2);
    chk("R2 low bytes sent", {16'h0, log_b[0], log_b[1]}, 32'h0000CCDD);
    rd(w);
    chk("R3 partial word", w, 32'h00006978);
  endtask

  task automatic t_burst_stop();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 0, 4'b0001, 2'd0, 4'd0, 12'd39));
    tx_wr(32'h01020304);
    tx_wr(32'h05060708);
    tx_wr(32'h090A0B0C);
    repeat (3) @(negedge clk);
    chk("R8 no start without trigger", 32'(log_n), 32'd0);
    ctrl_wr(mk(1, 1, 0, 4'b0001, 2'd0, 4'd0, 12'd39));
    wait_idle();
    chk("R2 remainder then full word", 32'(log_n), 32'd5);
    chk("R2 first word one byte", 32'(log_b[0]), 32'h04);
    chk("R2 second word", {log_b[1], log_b[2], log_b[3], log_b[4]}, 32'h05060708);
    chk("R5 stop leaves word", 32'(tx_empty), 32'd0);
    chk("R5 done flag", 32'(xfer_done), 32'd1);
    chk("R5 go kept", 32'(ctrl_rd[1]), 32'd1);
    rd(w);
    chk("R3 first rx", w, 32'h000000A1);
    rd(w);
    chk("R3 second rx", w, 32'hA0A3A2AD);
  endtask

  task automatic t_chain();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 0, 4'b0010, 2'd1, 4'b0010, 12'd15));
    chk("R9 cs ch1", 32'(cs_n), 32'hD);
    tx_wr(32'hAAAA1234);
    tx_wr(32'hBBBB5678);
    tx_wr(32'hCCCC9ABC);
    ctrl_wr(mk(1, 1, 0, 4'b0010, 2'd1, 4'b0010, 12'd15));
    wait_idle();
    chk("R6 all bursts sent", 32'(log_n), 32'd6);
    chk("R6 bytes", {log_b[2], log_b[3], log_b[4], log_b[5]}, 32'h56789ABC);
    chk("R6 queue drained", 32'(tx_empty), 32'd1);
    chk("R7 go cleared after chain", 32'(ctrl_rd[1]), 32'd0);
    rd(w); chk("R3 chain rx0", w, 32'h0000B791);
    rd(w); chk("R3 chain rx1", w, 32'h0000F3DD);
    rd(w); chk("R3 chain rx2", w, 32'h00003F19);
  endtask

  task automatic t_overflow();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd7));
    for (int i = 1; i <= 5; i++) begin
      tx_wr(32'(i));
      wait_idle();
      if (i == 4) chk("R4 no flag before full", 32'(rx_ovf), 32'd0);
    end
    chk("R4 overflow flag", 32'(rx_ovf), 32'd1);
    chk("R4 rx full", 32'(rx_full), 32'd1);
    repeat (3) @(negedge clk);
    chk("R4 flag sticky", 32'(rx_ovf), 32'd1);
    rd(w); chk("R4 oldest kept", w, 32'h000000A4);
    rd(w); rd(w); rd(w);
    chk("R4 last word dropped", w, 32'h000000A1);
    chk("R4 queue empty", 32'(rx_valid), 32'd0);
    clr(2'b01);
    chk("R4 flag cleared", 32'(rx_ovf), 32'd0);
  endtask

  task automatic t_auto_set();
    logic [31:0] w;
    fresh();
    ctrl_wr(mk(1, 0, 0, 4'b0001, 2'd0, 4'd0, 12'd7));
    tx_wr(32'h5A);
    repeat (3) @(negedge clk);
    chk("R8 held until auto-go", 32'(log_n), 32'd0);
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd7));
    wait_idle();
    chk("R8 auto-go set starts", 32'(log_n), 32'd1);
    rd(w);
    chk("R8 rx after auto-go", w, 32'h000000FF);
  endtask

  task automatic t_cs();
    fresh();
    ctrl_wr(mk(1, 0, 0, 4'b0100, 2'd2, 4'd0, 12'd7));
    chk("R9 cs ch2", 32'(cs_n), 32'hB);
    ctrl_wr(mk(1, 0, 0, 4'b0000, 2'd3, 4'd0, 12'd7));
    chk("R9 non-master keeps cs", 32'(cs_n), 32'hB);
  endtask

  task automatic t_abort();
    fresh();
    slave_lat = 50;
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd31));
    tx_wr(32'hDEAD0001);
    tx_wr(32'hDEAD0002);
    repeat (10) @(negedge clk);
    chk("R11 request held", {31'd0, spi_req}, 32'd1);
    chk("R11 byte held", 32'(spi_tx), 32'hDE);
    ctrl_wr(32'h0);
    chk("R10 abort stops", {spi_req, busy}, 32'd0);
    chk("R10 abort cs", 32'(cs_n), 32'hF);
    chk("R10 abort flush", 32'(tx_empty), 32'd1);
    tx_wr(32'h99);
    chk("R10 disabled write ignored", 32'(tx_empty), 32'd1);
    slave_lat = 2;
    log_n = 0;
    ctrl_wr(mk(1, 0, 1, 4'b0001, 2'd0, 4'd0, 12'd7));
    tx_wr(32'h77);
    wait_idle();
    chk("R10 burst count reset", 32'(log_n), 32'd1);
    chk("R10 byte after abort", 32'(log_b[0]), 32'h77);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_round();
    t_burst_stop();
    t_chain();
    t_overflow();
    t_auto_set();
    t_cs();
    t_abort();
    finish_run();
  end
endmodule